// File: doc/BRIEF.md
# Register-Mapped Random Word Source

This block is a random number peripheral that a processor reaches through three 32-bit registers on a single-cycle read/write bus. A control register switches word generation on and off and masks the interrupt. A status register reports whether a word is waiting and carries the seed-fault flags. Software pulls random words from a data register. The words come from a 32-bit LFSR that stands in for an entropy source. It produces one word every `GEN_INTERVAL` cycles into a four-word buffer and pauses while the buffer is full.

A seed fault is raised by the `fault_inject` pin. It stops generation, empties the buffer and sets two sticky flags. To recover, software writes zero to the interrupt flag. It then reads the data register a fixed number of times and discards what it gets, which flushes the generation path. When the last of those reads completes, the current-fault flag drops and normal output resumes.

The bus accepts a request in every cycle and never stalls. Read data is returned with `bus_rvalid` one cycle after the request. There is no back-pressure on the bus. The only flow control on random words is the data-ready status bit, and software must poll it.

Top module: `entropy_port`

## Requirements
- R1: Registers sit at offsets 0x0 (control), 0x4 (status) and 0x8 (data). A read request returns its value on `bus_rdata` with `bus_rvalid` high in the next cycle. Any other offset reads as zero.
- R2: Control bit 2 enables generation, bit 3 enables the interrupt and bit 5 is a stored clock-check bit. These are the only bits that read back, and all are zero after reset. Writing a control word with bit 2 clear disables generation and empties the buffer. When generation is enabled again, the word sequence continues from where the LFSR stopped.
- R3: While enabled, a word is added every GEN_INTERVAL (default 16) cycles until four words are buffered. Starting from a seed of 1, each word is the next state s' = (s >> 1) ^ (s[0] ? 0x80200003 : 0). Words are read out oldest first.
- R4: Status bit 0 (data ready) is high when the buffer holds a word and no seed fault is current. Each data read removes one word, and bit 0 falls as soon as the last word has been read.
- R5: A data read with the buffer empty returns zero and changes no state.
- R6: A pulse on `fault_inject` while enabled sets status bit 2 (fault current) and bit 6 (fault interrupt). It also empties the buffer and stops generation for as long as both bits are set.
- R7: Status bit 6 is cleared only by a status write with bit 6 at 0. Writing 1 to bit 6 has no effect. Status bits 1 and 5 always read 0.
- R8: After bit 6 is cleared, generation runs again. The next 12 data reads are discarded flush reads, and they count even when the buffer is empty. Bit 2 stays set until the 12th such read, then clears. Data ready then returns and bit 6 stays 0.
- R9: `irq` is high exactly while control bit 3 and status bit 6 are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Bus request strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| bus_rdata | output | 32 | Read data |
| fault_inject | input | 1 | Raises a seed fault when generation is enabled |
| irq | output | 1 | Seed-fault interrupt |

## Verification
A register read is answered one cycle after its request, so the bench samples `bus_rdata` at the falling edge that follows the request's rising edge. A write or a fault pulse takes effect at the next rising edge. The bench therefore reads status only after that edge has passed, and `irq` is sampled one cycle after the pulse. A new word arrives only GEN_INTERVAL cycles after the buffer stops being full. Drain checks are issued back to back within that window, and fill checks wait well beyond four intervals.

// File: rtl/entropy_pkg.sv
package entropy_pkg;
  localparam int ADDR_W = 4;
  localparam int REG_W  = 32;

  localparam logic [ADDR_W-1:0] OFF_CTRL = 4'h0;
  localparam logic [ADDR_W-1:0] OFF_STAT = 4'h4;
  localparam logic [ADDR_W-1:0] OFF_DATA = 4'h8;

  // control bit positions
  localparam int CB_GEN = 2;
  localparam int CB_IRQ = 3;
  localparam int CB_CLK = 5;

  // status bit positions
  localparam int SB_RDY     = 0;
  localparam int SB_CLK_NOW = 1;
  localparam int SB_SEED    = 2;
  localparam int SB_CLK_IRQ = 5;
  localparam int SB_SEED_IRQ = 6;
endpackage

// File: rtl/entropy_lfsr.sv
module entropy_lfsr #(
  parameter int          W    = 32,
  parameter logic [W-1:0] TAPS = 32'h8020_0003,
  parameter logic [W-1:0] SEED = 32'h0000_0001
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  output logic [W-1:0] state,
  output logic [W-1:0] nxt
);
  always_comb nxt = (state >> 1) ^ (state[0] ? TAPS : '0);

  always_ff @(posedge clk) begin
    if (!rst_n)     state <= SEED;
    else if (step)  state <= nxt;
  end
endmodule

// File: rtl/entropy_fifo.sv
module entropy_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic          empty,
  output logic          full
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic          push_ok, pop_ok;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign dout    = mem[rd_q];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_q] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      wr_q  <= '0;
      rd_q  <= '0;
      count <= '0;
    end else begin
      if (push_ok) wr_q <= bump(wr_q);
      if (pop_ok)  rd_q <= bump(rd_q);
      count <= count + CW'(push_ok) - CW'(pop_ok);
    end
  end
endmodule

// File: rtl/entropy_fault.sv
module entropy_fault #(
  parameter int FLUSH_READS = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fault_hit,
  input  logic irq_clear,
  input  logic data_read,
  output logic seed_now,
  output logic seed_irq
);
  localparam int CW = $clog2(FLUSH_READS+1);

  logic [CW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seed_now <= 1'b0;
      seed_irq <= 1'b0;
      left_q   <= '0;
    end else if (fault_hit) begin
      seed_now <= 1'b1;
      seed_irq <= 1'b1;
      left_q   <= '0;
    end else if (irq_clear && seed_irq) begin
      seed_irq <= 1'b0;
      left_q   <= CW'(FLUSH_READS);
    end else if (seed_now && !seed_irq && data_read && left_q != '0) begin
      left_q <= left_q - 1'b1;
      if (left_q == CW'(1)) seed_now <= 1'b0;
    end
  end
endmodule

// File: rtl/entropy_port.sv
module entropy_port
  import entropy_pkg::*;
#(
  parameter int          FIFO_DEPTH   = 4,
  parameter int          GEN_INTERVAL = 16,
  parameter int          FLUSH_READS  = 12,
  parameter logic [31:0] LFSR_TAPS    = 32'h8020_0003,
  parameter logic [31:0] LFSR_SEED    = 32'h0000_0001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic              bus_rvalid,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              fault_inject,
  output logic              irq
);
  localparam int FILL_W = $clog2(FIFO_DEPTH+1);
  localparam int TW     = (GEN_INTERVAL > 1) ? $clog2(GEN_INTERVAL) : 1;

  logic gen_en, irq_en, clk_chk;
  logic wr_ctrl, wr_stat, rd_any, rd_data;
  logic seed_now, seed_irq, fault_hit, gen_ok;
  logic push, pop, fifo_clr, fifo_empty, fifo_full, data_rdy;
  logic [FILL_W-1:0] fill_level;
  logic [REG_W-1:0]  fifo_dout, lfsr_state, lfsr_nxt, ctrl_word, stat_word, rd_mux;
  logic [TW-1:0]     tick_q;

  assign wr_ctrl = bus_req && bus_we  && bus_addr == OFF_CTRL;
  assign wr_stat = bus_req && bus_we  && bus_addr == OFF_STAT;
  assign rd_any  = bus_req && !bus_we;
  assign rd_data = rd_any && bus_addr == OFF_DATA;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gen_en  <= 1'b0;
      irq_en  <= 1'b0;
      clk_chk <= 1'b0;
    end else if (wr_ctrl) begin
      gen_en  <= bus_wdata[CB_GEN];
      irq_en  <= bus_wdata[CB_IRQ];
      clk_chk <= bus_wdata[CB_CLK];
    end
  end

  assign fault_hit = fault_inject && gen_en;
  assign gen_ok    = gen_en && !(seed_now && seed_irq);

  // pacing of the entropy stand-in
  always_ff @(posedge clk) begin
    if (!rst_n || !gen_ok || fifo_full || fault_hit) tick_q <= '0;
    else if (tick_q == TW'(GEN_INTERVAL-1))          tick_q <= '0;
    else                                             tick_q <= tick_q + 1'b1;
  end

  assign push     = gen_ok && !fifo_full && !fault_hit && tick_q == TW'(GEN_INTERVAL-1);
  assign pop      = rd_data && !fifo_empty;
  assign fifo_clr = fault_hit || (wr_ctrl && !bus_wdata[CB_GEN]);
  assign data_rdy = !fifo_empty && !seed_now;

  entropy_lfsr #(.W(REG_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .step(push), .state(lfsr_state), .nxt(lfsr_nxt)
  );

  entropy_fifo #(.W(REG_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .clr(fifo_clr), .push(push), .din(lfsr_nxt),
    .pop(pop), .dout(fifo_dout), .count(fill_level),
    .empty(fifo_empty), .full(fifo_full)
  );

  entropy_fault #(.FLUSH_READS(FLUSH_READS)) u_fault (
    .clk(clk), .rst_n(rst_n), .fault_hit(fault_hit),
    .irq_clear(wr_stat && !bus_wdata[SB_SEED_IRQ]),
    .data_read(rd_data), .seed_now(seed_now), .seed_irq(seed_irq)
  );

  always_comb begin
    ctrl_word = '0;
    ctrl_word[CB_GEN] = gen_en;
    ctrl_word[CB_IRQ] = irq_en;
    ctrl_word[CB_CLK] = clk_chk;
    stat_word = '0;
    stat_word[SB_RDY]      = data_rdy;
    stat_word[SB_CLK_NOW]  = 1'b0;
    stat_word[SB_SEED]     = seed_now;
    stat_word[SB_CLK_IRQ]  = 1'b0;
    stat_word[SB_SEED_IRQ] = seed_irq;
    case (bus_addr)
      OFF_CTRL: rd_mux = ctrl_word;
      OFF_STAT: rd_mux = stat_word;
      OFF_DATA: rd_mux = fifo_empty ? '0 : fifo_dout;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= rd_any;
      if (rd_any) bus_rdata <= rd_mux;
    end
  end

  assign irq = irq_en && seed_irq;

  logic unused_bits;
  assign unused_bits = ^{bus_wdata, lfsr_state};
endmodule

// File: rtl/entropy_port_chk.sv
module entropy_port_chk
  import entropy_pkg::*;
#(
  parameter int FIFO_DEPTH = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_req,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [REG_W-1:0]  bus_wdata,
  input logic              bus_rvalid,
  input logic [REG_W-1:0]  bus_rdata,
  input logic              fault_inject,
  input logic              irq,
  input logic              gen_en,
  input logic              irq_en,
  input logic              seed_now,
  input logic              seed_irq,
  input logic [$clog2(FIFO_DEPTH+1)-1:0] fill_level,
  input logic [REG_W-1:0]  lfsr_state
);
  localparam int FILL_W = $clog2(FIFO_DEPTH+1);

  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_we |=> bus_rvalid); // R1

  AST_DISABLE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_we && bus_addr == OFF_CTRL && !bus_wdata[CB_GEN] |=> fill_level == '0); // R2

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    fill_level <= FILL_W'(FIFO_DEPTH)); // R3

  AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_we && bus_addr == OFF_DATA && fill_level == '0 |=> bus_rdata == '0); // R5

  AST_FAULT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    fault_inject && gen_en |=> seed_now && seed_irq && fill_level == '0); // R6

  AST_HALT_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    seed_now && seed_irq |=> $stable(lfsr_state)); // R6

  AST_ONE_KEEPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    seed_irq && bus_req && bus_we && bus_addr == OFF_STAT && bus_wdata[SB_SEED_IRQ] |=> seed_irq); // R7

  AST_IRQ_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    fault_inject && gen_en && irq_en && !(bus_req && bus_we) |=> irq); // R9
endmodule

bind entropy_port entropy_port_chk #(.FIFO_DEPTH(FIFO_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid),
  .bus_rdata(bus_rdata), .fault_inject(fault_inject), .irq(irq),
  .gen_en(gen_en), .irq_en(irq_en), .seed_now(seed_now), .seed_irq(seed_irq),
  .fill_level(fill_level), .lfsr_state(lfsr_state)
);

// File: tb/entropy_port_tb.sv
`timescale 1ns/1ps
module entropy_port_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rvalid;
  logic [31:0] bus_rdata;
  logic        fault_inject = 1'b0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] model_s = 32'h1;
  logic [31:0] rd;

  always #2.5 clk = ~clk;

  entropy_port u_dut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid),
    .bus_rdata(bus_rdata), .fault_inject(fault_inject), .irq(irq)
  );

  function automatic logic [31:0] nx(input logic [31:0] s);
    return (s >> 1) ^ (s[0] ? 32'h8020_0003 : 32'h0);
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_req = 1'b0;
    d = bus_rdata;
    checks++;
    if (bus_rvalid !== 1'b1) begin
      errors++;
      $display("FAIL R1 rvalid actual=%b expected=1", bus_rvalid);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  typedef struct packed {
    logic        wr;
    logic [3:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{1'b0, 4'h0, 32'h0,         32'h0,  8'd2},  // R2 reset value
    '{1'b0, 4'h4, 32'h0,         32'h0,  8'd4},  // R4 nothing ready
    '{1'b0, 4'hC, 32'h0,         32'h0,  8'd1},  // R1 unmapped
    '{1'b1, 4'h0, 32'hFFFF_FFFF, 32'h0,  8'd0},
    '{1'b0, 4'h0, 32'h0,         32'h2C, 8'd2},  // R2 only bits 2,3,5
    '{1'b1, 4'h0, 32'h0,         32'h0,  8'd0},
    '{1'b0, 4'h0, 32'h0,         32'h0,  8'd2},  // R2 disabled
    '{1'b0, 4'h8, 32'h0,         32'h0,  8'd5},  // R5 empty read
    '{1'b1, 4'h4, 32'h0,         32'h0,  8'd0},
    '{1'b0, 4'h4, 32'h0,         32'h0,  8'd7}   // R7 bits 1,5 zero
  };

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(4);
    rst_n = 1'b1;
    idle(1);
    chk({31'h0, bus_rvalid}, 32'h0, "R1 rvalid after reset");
    chk(bus_rdata, 32'h0, "R1 rdata after reset");
    chk({31'h0, irq}, 32'h0, "R9 irq after reset");

    for (int i = 0; i < 10; i++) begin
      if (VECS[i].wr) bus_write(VECS[i].addr, VECS[i].data);
      else begin
        bus_read(VECS[i].addr, rd);
        chk(rd, VECS[i].exp, $sformatf("R%0d vector %0d", VECS[i].req, i));
      end
    end

    // R3/R4: fill, read in order, drain
    bus_write(4'h0, 32'h2C);
    idle(100);
    bus_read(4'h4, rd); chk(rd, 32'h1, "R4 ready when full");
    for (int i = 0; i < 4; i++) begin
      model_s = nx(model_s);
      bus_read(4'h8, rd); chk(rd, model_s, "R3 word order");
    end
    bus_read(4'h4, rd); chk(rd, 32'h0, "R4 ready falls after last word");
    bus_read(4'h8, rd); chk(rd, 32'h0, "R5 empty read returns zero");
    bus_read(4'h4, rd); chk(rd, 32'h0, "R5 empty read leaves status");

    // R2: disable empties buffer, sequence continues on re-enable
    idle(100);
    bus_write(4'h0, 32'h0);
    for (int i = 0; i < 4; i++) model_s = nx(model_s);
    bus_read(4'h4, rd); chk(rd, 32'h0, "R2 disable clears ready");
    bus_read(4'h8, rd); chk(rd, 32'h0, "R2 disable empties buffer");
    bus_write(4'h0, 32'h2C);
    idle(100);
    model_s = nx(model_s);
    bus_read(4'h8, rd); chk(rd, model_s, "R2 sequence resumes");

    // R6/R7/R9: seed fault
    idle(100);
    fault_inject = 1'b1; idle(1); fault_inject = 1'b0;
    chk({31'h0, irq}, 32'h1, "R9 irq on fault");
    bus_read(4'h4, rd); chk(rd, 32'h44, "R6 fault flags");
    bus_read(4'h8, rd); chk(rd, 32'h0, "R6 buffer emptied");
    bus_write(4'h4, 32'hFFFF_FFFF);
    bus_read(4'h4, rd); chk(rd, 32'h44, "R7 writing one keeps flag");
    idle(60);
    bus_read(4'h4, rd); chk(rd, 32'h44, "R6 generation halted");

    // R8: recovery
    bus_write(4'h4, 32'h0);
    bus_read(4'h4, rd); chk(rd, 32'h04, "R8 interrupt flag cleared");
    chk({31'h0, irq}, 32'h0, "R9 irq drops with flag");
    idle(20);
    for (int i = 0; i < 11; i++) bus_read(4'h8, rd);
    bus_read(4'h4, rd); chk(rd & 32'h45, 32'h04, "R8 fault held before last flush read");
    bus_read(4'h8, rd);
    bus_read(4'h4, rd); chk(rd & 32'h46, 32'h0, "R8 fault clears after flush");
    idle(100);
    bus_read(4'h4, rd); chk(rd, 32'h1, "R8 ready returns");
    bus_read(4'h8, rd); chk({31'h0, rd != 32'h0}, 32'h1, "R8 output resumes");

    // R9: masked interrupt
    bus_write(4'h0, 32'h24);
    fault_inject = 1'b1; idle(1); fault_inject = 1'b0;
    chk({31'h0, irq}, 32'h0, "R9 irq masked");
    bus_read(4'h4, rd); chk(rd, 32'h44, "R6 fault with irq masked");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule